// File: doc/BRIEF.md
# Single-Master Bus Fabric with Timeout Watchdog

This block is a synchronous shared bus with one master port and a set of internal slave targets, each owning a small address window of word storage. The master begins a transaction by raising a start strobe for one cycle. In that same cycle it presents an operation (read or write), an address and write data. It then waits for a completion pulse. Every slave sees every accepted start and compares the address against its own window. Only the slave whose window matches latches the request, carries it out after its own fixed response delay, and signals completion.

A central watchdog arms a down-counter whenever a start is accepted and disarms it when any slave completes. If the counter runs out first, the watchdog ends the transaction itself. It raises the completion pulse together with an error flag and returns all-ones read data. An address that falls in no window therefore cannot stall the master. While a transaction is outstanding the fabric reports busy, and it ignores any further start until the completion cycle has passed.

Top module: `sbus_fabric`

## Requirements
- R1: While reset is asserted and after its release with no start, `m_done`, `m_err` and `m_busy` are low and `m_rdata` is zero.
- R2: A start sampled while `m_busy` is low is accepted. `m_busy` is high from the next cycle through the completion cycle, and it is low in the cycle after `m_done`.
- R3: Slave i (i = 0..NUM_SLV-1, default 3) owns the addresses whose bits [ADDR_W-1:WIN_SHIFT] (default [7:4]) equal i and whose bits [WIN_SHIFT-1:0] are below SLV_WORDS (default 4). No other address is owned by any slave.
- R4: A write to an owned address stores `m_wdata`. A later read of that address returns the stored word and leaves all other words unchanged. All storage words reset to zero.
- R5: `m_done` for slave i appears LAT cycles after the start, where LAT = BASE_LAT + i*LAT_STEP (default 1 + 2i). A latency of 1 means `m_done` is visible in the cycle right after the start edge.
- R6: A start to an address that no slave owns completes after exactly TIMEOUT cycles (default 16), counted the same way as R5. It completes with `m_err` high and `m_rdata` all ones.
- R7: `m_done` is a single-cycle pulse. `m_err` is high only together with `m_done`, and only for a timeout.
- R8: A start raised while `m_busy` is high, including during the completion cycle, is ignored. It changes neither storage nor the timing of the outstanding transaction.
- R9: A slave completion disarms the watchdog. The next transaction gets its full window, so a timeout following a served transaction still takes exactly TIMEOUT cycles.
- R10: `m_rdata` is zero in every cycle without `m_done` and on the completion of a write. It carries the read word only in the completion cycle of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_start | input | 1 | Start strobe from the master |
| m_write | input | 1 | Operation: 1 write, 0 read |
| m_addr | input | ADDR_W | Transaction address |
| m_wdata | input | DATA_W | Write data, held from start to done |
| m_done | output | 1 | Completion pulse |
| m_err | output | 1 | Timeout error, valid with m_done |
| m_rdata | output | DATA_W | Read data, valid with m_done |
| m_busy | output | 1 | Transaction outstanding |

## Verification
On every cycle the assertions check the handshake shape at the master port. They cover the single-cycle done pulse, error only with done and all-ones data with an error, and quiet read data outside done. They also cover busy rising after an accepted start, busy falling after done, and a busy span that never exceeds the watchdog window, with an error landing exactly on its last cycle. The address map, the stored contents, each slave's exact latency and the harmlessness of starts issued while busy can only be shown by the bench's scenarios. The bench sweeps every address with a write and then a read, and it overlaps a colliding start with a slow transaction.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } sbus_op_e;

  // Response delay of the slave at position idx in the window map
  function automatic int unsigned slave_latency(int unsigned base, int unsigned step,
                                                int unsigned idx);
    return base + step * idx;
  endfunction

endpackage

// File: rtl/sbus_watchdog.sv
module sbus_watchdog #(
  parameter int unsigned TIMEOUT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic done_i,
  output logic accept_o,
  output logic busy_o,
  output logic expire_o
);
  localparam int unsigned CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(TIMEOUT - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign accept_o = start_i && !busy_q;
  assign busy_o   = busy_q;
  assign expire_o = busy_q && (cnt_q == '0) && !done_i;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (accept_o) begin
      busy_d = 1'b1;
      cnt_d  = LOAD;
      cnt_en = 1'b1;
    end else if (busy_q && (done_i || cnt_q == '0)) begin
      busy_d = 1'b0;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (busy_q) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cnt_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

endmodule

// File: rtl/sbus_window_slave.sv
module sbus_window_slave
  import sbus_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned WIN_SHIFT = 4,
  parameter int unsigned SLV_WORDS = 4,
  parameter int unsigned IDX       = 0,
  parameter int unsigned LATENCY   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  sbus_op_e          op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned TAG_W = ADDR_W - WIN_SHIFT;
  localparam int unsigned OFS_W = (SLV_WORDS > 1) ? $clog2(SLV_WORDS) : 1;
  localparam int unsigned LAT_W = $clog2(LATENCY + 1);
  localparam logic [TAG_W-1:0] TAG  = TAG_W'(IDX);
  localparam logic [LAT_W-1:0] LLD  = LAT_W'(LATENCY - 1);

  logic              hit;
  logic              pend_q, pend_d;
  logic [LAT_W-1:0]  lat_q, lat_d;
  sbus_op_e          op_q, op_d;
  logic [OFS_W-1:0]  ofs_q, ofs_d;
  logic [DATA_W-1:0] wd_q, wd_d;
  logic              ctl_en, req_en;
  logic              mem_we;
  logic [DATA_W-1:0] mem_q [SLV_WORDS];

  // Window compare: tag field selects the slave, offset must fall inside storage
  assign hit = (addr_i[ADDR_W-1:WIN_SHIFT] == TAG) &&
               (32'(addr_i[WIN_SHIFT-1:0]) < SLV_WORDS);

  assign done_o  = pend_q && (lat_q == '0);
  assign mem_we  = done_o && (op_q == OP_WRITE);
  assign rdata_o = (done_o && op_q == OP_READ) ? mem_q[ofs_q] : '0;

  always_comb begin
    pend_d = pend_q;
    lat_d  = lat_q;
    op_d   = op_q;
    ofs_d  = ofs_q;
    wd_d   = wd_q;
    ctl_en = 1'b0;
    req_en = 1'b0;
    if (start_i && hit) begin
      pend_d = 1'b1;
      lat_d  = LLD;
      op_d   = op_i;
      ofs_d  = addr_i[OFS_W-1:0];
      wd_d   = wdata_i;
      ctl_en = 1'b1;
      req_en = 1'b1;
    end else if (done_o) begin
      pend_d = 1'b0;
      ctl_en = 1'b1;
    end else if (pend_q) begin
      lat_d  = lat_q - 1'b1;
      ctl_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      lat_q  <= '0;
    end else if (ctl_en) begin
      pend_q <= pend_d;
      lat_q  <= lat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= OP_READ;
      ofs_q <= '0;
      wd_q  <= '0;
    end else if (req_en) begin
      op_q  <= op_d;
      ofs_q <= ofs_d;
      wd_q  <= wd_d;
    end
  end

  for (genvar w = 0; w < SLV_WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[w] <= '0;
      end else if (mem_we && ofs_q == OFS_W'(w)) begin
        mem_q[w] <= wd_q;
      end
    end
  end

endmodule

// File: rtl/sbus_resp_merge.sv
module sbus_resp_merge #(
  parameter int unsigned NUM_SLV = 3,
  parameter int unsigned DATA_W  = 16
) (
  input  logic [NUM_SLV-1:0]             slv_done_i,
  input  logic [NUM_SLV-1:0][DATA_W-1:0] slv_rdata_i,
  input  logic                           expire_i,
  output logic                           any_done_o,
  output logic                           done_o,
  output logic                           err_o,
  output logic [DATA_W-1:0]              rdata_o
);
  logic [DATA_W-1:0] or_data;

  // Windows are disjoint and idle slaves drive zero, so an OR tree is the mux
  always_comb begin
    or_data = '0;
    for (int i = 0; i < NUM_SLV; i++) begin
      or_data = or_data | slv_rdata_i[i];
    end
  end

  assign any_done_o = |slv_done_i;
  assign done_o     = any_done_o || expire_i;
  assign err_o      = expire_i;
  assign rdata_o    = expire_i ? '1 : or_data;

endmodule

// File: rtl/sbus_fabric.sv
module sbus_fabric
  import sbus_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned NUM_SLV   = 3,
  parameter int unsigned WIN_SHIFT = 4,
  parameter int unsigned SLV_WORDS = 4,
  parameter int unsigned BASE_LAT  = 1,
  parameter int unsigned LAT_STEP  = 2,
  parameter int unsigned TIMEOUT   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              m_start,
  input  logic              m_write,
  input  logic [ADDR_W-1:0] m_addr,
  input  logic [DATA_W-1:0] m_wdata,
  output logic              m_done,
  output logic              m_err,
  output logic [DATA_W-1:0] m_rdata,
  output logic              m_busy
);
  logic                           accept;
  logic                           expire;
  logic                           any_done;
  logic [NUM_SLV-1:0]             slv_done;
  logic [NUM_SLV-1:0][DATA_W-1:0] slv_rdata;
  sbus_op_e                       op;

  assign op = sbus_op_e'(m_write);

  sbus_watchdog #(
    .TIMEOUT (TIMEOUT)
  ) u_wdog (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (m_start),
    .done_i   (any_done),
    .accept_o (accept),
    .busy_o   (m_busy),
    .expire_o (expire)
  );

  for (genvar i = 0; i < NUM_SLV; i++) begin : g_slv
    sbus_window_slave #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .WIN_SHIFT (WIN_SHIFT),
      .SLV_WORDS (SLV_WORDS),
      .IDX       (i),
      .LATENCY   (slave_latency(BASE_LAT, LAT_STEP, i))
    ) u_slv (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (accept),
      .op_i    (op),
      .addr_i  (m_addr),
      .wdata_i (m_wdata),
      .done_o  (slv_done[i]),
      .rdata_o (slv_rdata[i])
    );
  end

  sbus_resp_merge #(
    .NUM_SLV (NUM_SLV),
    .DATA_W  (DATA_W)
  ) u_merge (
    .slv_done_i  (slv_done),
    .slv_rdata_i (slv_rdata),
    .expire_i    (expire),
    .any_done_o  (any_done),
    .done_o      (m_done),
    .err_o       (m_err),
    .rdata_o     (m_rdata)
  );

endmodule

// File: rtl/sbus_fabric_chk.sv
module sbus_fabric_chk #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned TIMEOUT = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              m_start,
  input logic              m_done,
  input logic              m_err,
  input logic [DATA_W-1:0] m_rdata,
  input logic              m_busy
);
  localparam int unsigned CW = $clog2(TIMEOUT + 2);

  logic [CW-1:0] busy_cycles;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cycles <= '0;
    end else if (!m_busy) begin
      busy_cycles <= '0;
    end else if (busy_cycles != '1) begin
      busy_cycles <= busy_cycles + 1'b1;
    end
  end

  // R7
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_err |-> m_done);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_done |=> !m_done);

  // R2
  busy_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_start && !m_busy) |=> m_busy);

  // R2
  idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_done |=> !m_busy);

  // R2
  done_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_done |-> m_busy);

  // R6
  err_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_err |-> (m_rdata == '1));

  // R10
  rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !m_done |-> (m_rdata == '0));

  // R9
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_busy |-> (32'(busy_cycles) < TIMEOUT));

  // R6
  err_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_err |-> (32'(busy_cycles) == TIMEOUT - 1));

endmodule

bind sbus_fabric sbus_fabric_chk #(
  .DATA_W  (DATA_W),
  .TIMEOUT (TIMEOUT)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .m_start (m_start),
  .m_done  (m_done),
  .m_err   (m_err),
  .m_rdata (m_rdata),
  .m_busy  (m_busy)
);

// File: tb/sim_sbus_fabric.sv
module sim_sbus_fabric;
  localparam int CLK_PERIOD = 10;
  localparam int NSLV = 3;
  localparam int NWORD = 4;
  localparam int TMO = 16;

  logic        clk;
  logic        rst_n;
  logic        m_start;
  logic        m_write;
  logic [7:0]  m_addr;
  logic [15:0] m_wdata;
  logic        m_done;
  logic        m_err;
  logic [15:0] m_rdata;
  logic        m_busy;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [15:0] model [NSLV][NWORD];

  sbus_fabric u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .m_start (m_start),
    .m_write (m_write),
    .m_addr  (m_addr),
    .m_wdata (m_wdata),
    .m_done  (m_done),
    .m_err   (m_err),
    .m_rdata (m_rdata),
    .m_busy  (m_busy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit mapped(input logic [7:0] a);
    return (int'(a >> 4) < NSLV) && (int'(a & 8'hF) < NWORD);
  endfunction

  function automatic int exp_lat(input logic [7:0] a);
    return mapped(a) ? 1 + 2 * int'(a >> 4) : TMO;
  endfunction

  function automatic logic [15:0] pat(input logic [7:0] a);
    return 16'hA500 ^ (16'(a) * 16'd37);
  endfunction

  task automatic do_txn(input logic wr, input logic [7:0] a, input logic [15:0] d,
                        output logic [15:0] rd, output logic er, output int lat);
    @(negedge clk);
    m_start = 1'b1; m_write = wr; m_addr = a; m_wdata = d;
    @(negedge clk);
    m_start = 1'b0;
    lat = 1;
    while (!m_done && lat < 100) begin
      chk(m_busy, "R2 busy while pending", m_busy, 1);
      chk(m_rdata == 16'h0, "R10 rdata quiet", m_rdata, 0);
      @(negedge clk);
      lat++;
    end
    rd = m_rdata;
    er = m_err;
    @(negedge clk);
    chk(!m_busy && !m_done, "R2/R7 idle after done", {m_busy, m_done}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    logic        er;
    int          lat;
    m_start = 1'b0; m_write = 1'b0; m_addr = '0; m_wdata = '0;
    rst_n = 1'b0;
    for (int s = 0; s < NSLV; s++) for (int w = 0; w < NWORD; w++) model[s][w] = '0;
    repeat (3) @(negedge clk);
    chk(!m_done && !m_err && !m_busy && m_rdata == 0, "R1 in reset",
        {m_done, m_err, m_busy}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!m_done && !m_err && !m_busy && m_rdata == 0, "R1 after release",
        {m_done, m_err, m_busy}, 0);

    // R4: reset contents read as zero
    do_txn(1'b0, 8'h12, '0, rd, er, lat);
    chk(rd == 16'h0 && !er, "R4 reset word zero", rd, 0);

    // R3 R5 R6 R9 R10: write sweep over the whole address space
    for (int a = 0; a < 256; a++) begin
      do_txn(1'b1, 8'(a), pat(8'(a)), rd, er, lat);
      chk(lat == exp_lat(8'(a)), "R5/R6/R9 write latency", lat, exp_lat(8'(a)));
      if (mapped(8'(a))) begin
        chk(!er, "R3 mapped write no error", er, 0);
        chk(rd == 16'h0, "R10 write rdata zero", rd, 0);
        model[a >> 4][a & 15] = pat(8'(a));
      end else begin
        chk(er, "R6 unmapped write error", er, 1);
        chk(rd == 16'hFFFF, "R6 error rdata ones", rd, 16'hFFFF);
      end
    end

    // R3 R4 R5 R6: read sweep
    for (int a = 255; a >= 0; a--) begin
      do_txn(1'b0, 8'(a), 16'h0, rd, er, lat);
      chk(lat == exp_lat(8'(a)), "R5/R6 read latency", lat, exp_lat(8'(a)));
      if (mapped(8'(a))) begin
        chk(!er && rd == model[a >> 4][a & 15], "R4 read data", rd,
            model[a >> 4][a & 15]);
      end else begin
        chk(er && rd == 16'hFFFF, "R6 unmapped read", rd, 16'hFFFF);
      end
    end

    // R8: a colliding start held through a slow slave-2 write is ignored
    @(negedge clk);
    m_start = 1'b1; m_write = 1'b1; m_addr = 8'h21; m_wdata = 16'h1234;
    @(negedge clk);
    m_addr = 8'h01; m_wdata = 16'hDEAD;
    lat = 1;
    while (!m_done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == 5 && !m_err, "R8 outstanding timing kept", lat, 5);
    @(negedge clk);
    m_start = 1'b0;
    chk(!m_busy, "R8 start during done cycle ignored", m_busy, 0);
    model[2][1] = 16'h1234;
    do_txn(1'b0, 8'h01, '0, rd, er, lat);
    chk(rd == model[0][1], "R8 ignored write left storage", rd, model[0][1]);
    do_txn(1'b0, 8'h21, '0, rd, er, lat);
    chk(rd == 16'h1234, "R4 accepted write stored", rd, 16'h1234);

    // R9: timeout right after a served transaction still takes the full window
    do_txn(1'b0, 8'h00, '0, rd, er, lat);
    do_txn(1'b0, 8'h3F, '0, rd, er, lat);
    chk(lat == TMO && er, "R9 full window after served", lat, TMO);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule